// File: doc/BRIEF.md
# Keyed-Write Watchdog and Interval Timer

This block is an 8-bit up-counter that works either as a watchdog or as a periodic interval timer. Software reaches it through one 16-bit write port at a single shared address. The upper byte of each write is a key that selects the target. With key 0x5A the lower byte loads the counter. With key 0xA5 the lower byte loads the control word. A write with any other key, and any byte-wide write, is dropped. This makes a stray or partial store unlikely to disturb the timer.

Three byte-wide read ports always show the counter, the control word and the status word. A one-cycle read strobe tells the block that software has read the status word.

In interval mode, every wrap of the counter from 0xFF to 0x00 produces a one-cycle interrupt and sets a sticky interval flag. In watchdog mode, a wrap sets an overflow flag and returns the counter and control word to their power-on values. If reset-enable is set, the wrap also drives a chip reset output for a fixed number of cycles. The overflow flag can be cleared only by reading it while it is set and then writing 0 to it.

Top module: `wdt_keyed`

## Requirements
- R1: After power-on reset the block reads as follows: counter 0x00, control 0x48, status 0x1F, with irq_o and chip_rst_o low.
- R2: A word write (wr_en=1, wr_word=1) whose upper byte is 0x5A loads the lower byte into the counter, visible on rd_cnt_o in the next cycle.
- R3: A word write with key 0xA5 loads the control bits from the lower byte, which is laid out as follows:
  - bit 7: write 0 to clear the overflow flag (see R9)
  - bit 6: reset-enable
  - bit 5: mode (1 = watchdog, 0 = interval)
  - bit 4: timer-enable
  - bit 3: write 0 to clear the interval flag
  - bits 2:0: clock select

  A word write with any other upper byte changes nothing.
- R4: A byte-wide write (wr_en=1, wr_word=0) changes neither the counter nor any control or status bit, whatever its key.
- R5: While timer-enable is 1, the counter advances once every N cycles, where N depends on the clock-select code: 0→2, 1→8, 2→32, 3→64, 4→256, 5→512, 6→2048, 7→4096. After enable is set from the disabled state, the k-th increment lands k·N cycles after the write edge. While disabled, the counter holds its value.
- R6: A control write that changes timer-enable from 1 to 0 forces the counter to 0x00.
- R7: In interval mode, a wrap from 0xFF to 0x00 raises irq_o for exactly one cycle and sets the interval flag (rd_ctl_o bit 7). It does not set the overflow flag and does not assert chip_rst_o. A control write with bit 3 = 0 clears the interval flag.
- R8: In watchdog mode, a wrap sets the overflow flag (rd_stat_o bit 7). In the same cycle it returns the counter to 0x00 and the control read to 0x48; reset-enable keeps its value.
- R9: The overflow flag clears only on a key-0xA5 word write with bit 7 = 0 that follows a status read made while the flag was set. Such a write consumes the read. A write of 0 without that read, or a write of 1, leaves the flag as it was. Software can never set the flag.
- R10: A watchdog wrap with reset-enable = 1 drives chip_rst_o high for exactly 518 cycles, starting the cycle after the wrap. With reset-enable = 0, chip_rst_o stays low.
- R11: Read layouts are as follows. rd_stat_o = {overflow flag, reset-enable, 0, 5'b11111}. rd_ctl_o = {interval flag, 1, mode, enable, 1, clock select[2:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| wr_en | input | 1 | Write strobe for the shared address |
| wr_word | input | 1 | 1 = 16-bit transfer, 0 = byte transfer |
| wr_data | input | 16 | Key byte in [15:8], payload in [7:0] |
| rd_stat_stb | input | 1 | One-cycle pulse: software read the status word |
| rd_cnt_o | output | 8 | Counter value |
| rd_ctl_o | output | 8 | Control word readback |
| rd_stat_o | output | 8 | Status word readback |
| irq_o | output | 1 | Interval interrupt pulse |
| chip_rst_o | output | 1 | Chip reset request |

## Verification
The assertions assume that software does not re-arm a watchdog wrap while a reset pulse is still running, so each pulse is measured as one unbroken window. They also assume that a key-0x5A load or a disable never coincides with a wrap, so every wrap they see comes from counting alone. The stimulus meets both conditions in three ways:
- Every watchdog run starts from 0xFE with the fastest divider.
- The bench waits out the full reset window before it writes again.
- Writes are issued only while the timer is disabled, or far from a wrap.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
  localparam logic [7:0] KEY_CNT = 8'h5A;
  localparam logic [7:0] KEY_CTL = 8'hA5;
  localparam int         DATA_W  = 8;

  // payload bit positions of a control write
  localparam int B_FCLR = 7;
  localparam int B_RSTE = 6;
  localparam int B_MODE = 5;
  localparam int B_EN   = 4;
  localparam int B_ICLR = 3;

  typedef struct packed {
    logic       rst_en;
    logic       wd_mode;
    logic       en;
    logic [2:0] sel;
  } ctl_t;

  localparam ctl_t CTL_INIT = '{rst_en: 1'b0, wd_mode: 1'b0, en: 1'b0, sel: 3'd0};

  // log2 of the prescaler divide ratio for each clock-select code
  function automatic int presc_shift(input logic [2:0] code);
    case (code)
      3'd0:    presc_shift = 1;
      3'd1:    presc_shift = 3;
      3'd2:    presc_shift = 5;
      3'd3:    presc_shift = 6;
      3'd4:    presc_shift = 8;
      3'd5:    presc_shift = 9;
      3'd6:    presc_shift = 11;
      default: presc_shift = 12;
    endcase
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PW = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [2:0] sel,
  output logic       tick
);
  import wdt_keyed_pkg::*;

  logic [PW-1:0] div_q;
  logic [PW-1:0] mask;

  always_comb begin
    mask = {PW{1'b1}} >> (PW - presc_shift(sel));
    tick = en && ((div_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   div_q <= '0;
    else if (!en) div_q <= '0;
    else          div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_q;

  assign cnt  = cnt_q;
  assign wrap = tick && !clr && !load && (cnt_q == {W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_word,
  input  logic [15:0] wr_data,
  input  logic        rd_stat_stb,
  input  logic        wrap,
  output logic        cnt_load,
  output logic [7:0]  cnt_load_val,
  output logic        cnt_clr,
  output wdt_keyed_pkg::ctl_t ctl,
  output logic        wd_flag,
  output logic        iv_flag,
  output logic        irq,
  output logic        rst_trig
);
  import wdt_keyed_pkg::*;

  ctl_t       ctl_q;
  logic       wdf_q, ivf_q, arm_q, irq_q;
  logic [7:0] key, pay;
  logic       word_ok, ctl_wr, wd_ovf, iv_ovf;

  always_comb begin
    key          = wr_data[15:8];
    pay          = wr_data[7:0];
    word_ok      = wr_en && wr_word;
    cnt_load     = word_ok && (key == KEY_CNT);
    cnt_load_val = pay;
    ctl_wr       = word_ok && (key == KEY_CTL);
    cnt_clr      = ctl_wr && ctl_q.en && !pay[B_EN];
    wd_ovf       = wrap && ctl_q.wd_mode;
    iv_ovf       = wrap && !ctl_q.wd_mode;
    rst_trig     = wd_ovf && ctl_q.rst_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_INIT;
      wdf_q <= 1'b0;
      ivf_q <= 1'b0;
      arm_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= iv_ovf;
      if (rd_stat_stb && wdf_q) arm_q <= 1'b1;
      if (wd_ovf) begin
        wdf_q         <= 1'b1;
        arm_q         <= 1'b0;
        ivf_q         <= 1'b0;
        ctl_q.wd_mode <= CTL_INIT.wd_mode;
        ctl_q.en      <= CTL_INIT.en;
        ctl_q.sel     <= CTL_INIT.sel;
      end else begin
        if (ctl_wr) begin
          ctl_q.rst_en  <= pay[B_RSTE];
          ctl_q.wd_mode <= pay[B_MODE];
          ctl_q.en      <= pay[B_EN];
          ctl_q.sel     <= pay[2:0];
          if (!pay[B_ICLR]) ivf_q <= 1'b0;
          if (!pay[B_FCLR] && arm_q) wdf_q <= 1'b0;
          arm_q <= 1'b0;
        end
        if (iv_ovf) ivf_q <= 1'b1;
      end
    end
  end

  assign ctl     = ctl_q;
  assign wd_flag = wdf_q;
  assign iv_flag = ivf_q;
  assign irq     = irq_q;
endmodule

// File: rtl/wdt_rst_stretch.sv
module wdt_rst_stretch #(
  parameter int N = 518
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic rst_out
);
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (trig)           left_q <= CW'(N);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign rst_out = (left_q != '0);
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int RST_CYCLES = 518,
  parameter int PRESC_W    = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_word,
  input  logic [15:0] wr_data,
  input  logic        rd_stat_stb,
  output logic [7:0]  rd_cnt_o,
  output logic [7:0]  rd_ctl_o,
  output logic [7:0]  rd_stat_o,
  output logic        irq_o,
  output logic        chip_rst_o
);
  import wdt_keyed_pkg::*;

  ctl_t       ctl;
  logic       tick, wrap, cnt_load, cnt_clr, wd_flag, iv_flag, rst_trig;
  logic [7:0] cnt_load_val, cnt;

  wdt_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_word      (wr_word),
    .wr_data      (wr_data),
    .rd_stat_stb  (rd_stat_stb),
    .wrap         (wrap),
    .cnt_load     (cnt_load),
    .cnt_load_val (cnt_load_val),
    .cnt_clr      (cnt_clr),
    .ctl          (ctl),
    .wd_flag      (wd_flag),
    .iv_flag      (iv_flag),
    .irq          (irq_o),
    .rst_trig     (rst_trig)
  );

  wdt_prescaler #(.PW(PRESC_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ctl.en),
    .sel   (ctl.sel),
    .tick  (tick)
  );

  wdt_counter #(.W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cnt_clr),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .tick     (tick),
    .cnt      (cnt),
    .wrap     (wrap)
  );

  wdt_rst_stretch #(.N(RST_CYCLES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig    (rst_trig),
    .rst_out (chip_rst_o)
  );

  assign rd_cnt_o  = cnt;
  assign rd_stat_o = {wd_flag, ctl.rst_en, 1'b0, 5'b11111};
  assign rd_ctl_o  = {iv_flag, 1'b1, ctl.wd_mode, ctl.en, 1'b1, ctl.sel};
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int RST_CYCLES = 518
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_word,
  input logic [7:0] rd_cnt_o,
  input logic [7:0] rd_ctl_o,
  input logic [7:0] rd_stat_o,
  input logic       irq_o,
  input logic       chip_rst_o
);
  int unsigned hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hi_cnt <= 0;
    else if (chip_rst_o) hi_cnt <= hi_cnt + 1;
    else                 hi_cnt <= 0;
  end

  // R4: a byte write to a stopped timer leaves every readback untouched
  a_r4_byte_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_word && !rd_ctl_o[4]) |=>
      ($stable(rd_cnt_o) && $stable(rd_ctl_o) && $stable(rd_stat_o)));

  // R7: interval interrupt lasts a single cycle
  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  // R7: interrupt only from an interval-mode wrap, with its flag set
  a_r7_irq_interval: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (!$past(rd_ctl_o[5]) && rd_ctl_o[7] && rd_cnt_o == 8'h00));

  // R9: the overflow flag rises only from a watchdog-mode wrap
  a_r9_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_stat_o[7]) |->
      ($past(rd_cnt_o) == 8'hFF && $past(rd_ctl_o[5]) && $past(rd_ctl_o[4])));

  // R8: watchdog wrap returns counter and control to initial values
  a_r8_wd_restore: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_stat_o[7]) |-> (rd_ctl_o == 8'h48 && rd_cnt_o == 8'h00));

  // R10: chip reset only when reset-enable was set
  a_r10_rst_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chip_rst_o) |-> $past(rd_stat_o[6]));

  // R10: reset window no shorter than the configured length
  a_r10_rst_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chip_rst_o) |-> (hi_cnt >= RST_CYCLES));

  // R11: constant status bits
  a_r11_stat_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat_o[5:0] == 6'b011111));
endmodule

bind wdt_keyed wdt_keyed_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_word    (wr_word),
  .rd_cnt_o   (rd_cnt_o),
  .rd_ctl_o   (rd_ctl_o),
  .rd_stat_o  (rd_stat_o),
  .irq_o      (irq_o),
  .chip_rst_o (chip_rst_o)
);

// File: tb/wdt_keyed_tb_top.sv
module wdt_keyed_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_word = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_stat_stb = 1'b0;
  logic [7:0]  rd_cnt_o, rd_ctl_o, rd_stat_o;
  logic        irq_o, chip_rst_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  wdt_keyed dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_word     (wr_word),
    .wr_data     (wr_data),
    .rd_stat_stb (rd_stat_stb),
    .rd_cnt_o    (rd_cnt_o),
    .rd_ctl_o    (rd_ctl_o),
    .rd_stat_o   (rd_stat_o),
    .irq_o       (irq_o),
    .chip_rst_o  (chip_rst_o)
  );

  // {word, key, payload, exp_cnt, exp_ctl, exp_stat}
  localparam logic [40:0] VEC [10] = '{
    {1'b1, 8'hA5, 8'h03, 8'h00, 8'h4B, 8'h1F},  // R3 clock select field
    {1'b1, 8'h5A, 8'h37, 8'h37, 8'h4B, 8'h1F},  // R2 counter load
    {1'b0, 8'h5A, 8'h99, 8'h37, 8'h4B, 8'h1F},  // R4 byte, counter key
    {1'b0, 8'hA5, 8'h07, 8'h37, 8'h4B, 8'h1F},  // R4 byte, control key
    {1'b1, 8'h33, 8'h12, 8'h37, 8'h4B, 8'h1F},  // R3 bad key
    {1'b1, 8'h5A, 8'hFF, 8'hFF, 8'h4B, 8'h1F},  // R2 load max
    {1'b1, 8'hA5, 8'h45, 8'hFF, 8'h4D, 8'h5F},  // R3 R11 reset-enable
    {1'b1, 8'hA5, 8'h00, 8'hFF, 8'h48, 8'h1F},  // R3 back to defaults
    {1'b1, 8'hA5, 8'h80, 8'hFF, 8'h48, 8'h1F},  // R9 software cannot set flag
    {1'b1, 8'h5A, 8'h00, 8'h00, 8'h48, 8'h1F}   // R2 load zero
  };

  localparam int RATIO [8] = '{2, 8, 32, 64, 256, 512, 2048, 4096};

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input bit word, input logic [7:0] key, input logic [7:0] pay);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_word = word;
    wr_data = {key, pay};
    @(negedge clk);
    wr_en   = 1'b0;
    wr_word = 1'b0;
    wr_data = '0;
  endtask

  task automatic rd_stat();
    @(negedge clk);
    rd_stat_stb = 1'b1;
    @(negedge clk);
    rd_stat_stb = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    int hi, first, irqs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "cnt", rd_cnt_o, 8'h00);
    chk("R1", "ctl", rd_ctl_o, 8'h48);
    chk("R1", "stat", rd_stat_o, 8'h1F);
    chk("R1", "irq", irq_o, 0);
    chk("R1", "rst", chip_rst_o, 0);

    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][40], VEC[i][39:32], VEC[i][31:24]);
      chk("vec", $sformatf("%0d cnt", i), rd_cnt_o, VEC[i][23:16]);
      chk("vec", $sformatf("%0d ctl", i), rd_ctl_o, VEC[i][15:8]);
      chk("vec", $sformatf("%0d stat", i), rd_stat_o, VEC[i][7:0]);
    end

    // R5 divide ratio for every clock-select code
    for (int c = 0; c < 8; c++) begin
      wr(1'b1, 8'h5A, 8'h00);
      wr(1'b1, 8'hA5, 8'h10 | 8'(c));
      repeat (2 * RATIO[c] - 1) @(negedge clk);
      chk("R5", $sformatf("code %0d before", c), rd_cnt_o, 1);
      @(negedge clk);
      chk("R5", $sformatf("code %0d at", c), rd_cnt_o, 2);
      wr(1'b1, 8'hA5, 8'h00);
      // R6 disable forces zero
      chk("R6", "cleared", rd_cnt_o, 0);
    end
    // R5 counter holds while disabled
    wr(1'b1, 8'h5A, 8'h21);
    repeat (20) @(negedge clk);
    chk("R5", "hold disabled", rd_cnt_o, 8'h21);

    // R7 interval wrap
    wr(1'b1, 8'h5A, 8'hF0);
    wr(1'b1, 8'hA5, 8'h10);
    repeat (16) @(negedge clk);
    chk("R5", "after 16", rd_cnt_o, 8'hF8);
    irqs = 0; first = -1; hi = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (irq_o) begin irqs++; if (first < 0) first = i; end
      if (chip_rst_o) hi++;
    end
    chk("R7", "irq count", irqs, 1);
    chk("R7", "irq cycle", first, 16);
    chk("R7", "no reset", hi, 0);
    chk("R7", "iflag ctl", rd_ctl_o, 8'hD8);
    chk("R7", "no wd flag", rd_stat_o, 8'h1F);
    wr(1'b1, 8'hA5, 8'h10);
    chk("R7", "iflag cleared", rd_ctl_o, 8'h58);
    chk("R6", "running nonzero", int'(rd_cnt_o != 0), 1);
    wr(1'b1, 8'hA5, 8'h00);
    chk("R6", "disable zero", rd_cnt_o, 0);

    // R8 watchdog wrap without reset-enable
    wr(1'b1, 8'h5A, 8'hFE);
    wr(1'b1, 8'hA5, 8'h30);
    hi = 0; irqs = 0;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (chip_rst_o) hi++;
      if (irq_o) irqs++;
    end
    chk("R10", "no reset when disabled", hi, 0);
    chk("R8", "no irq", irqs, 0);
    chk("R8", "flag", rd_stat_o, 8'h9F);
    chk("R8", "ctl restored", rd_ctl_o, 8'h48);
    chk("R8", "cnt zero", rd_cnt_o, 0);

    // R9 clear sequence
    wr(1'b1, 8'hA5, 8'h00);
    chk("R9", "write without read", rd_stat_o, 8'h9F);
    rd_stat();
    wr(1'b1, 8'hA5, 8'h80);
    chk("R9", "write one after read", rd_stat_o, 8'h9F);
    wr(1'b1, 8'hA5, 8'h00);
    chk("R9", "read consumed", rd_stat_o, 8'h9F);
    rd_stat();
    wr(1'b0, 8'hA5, 8'h00);
    chk("R9", "byte write no clear", rd_stat_o, 8'h9F);
    wr(1'b1, 8'hA5, 8'h00);
    chk("R9", "cleared", rd_stat_o, 8'h1F);

    // R10 watchdog wrap with reset-enable
    wr(1'b1, 8'hA5, 8'h40);
    wr(1'b1, 8'h5A, 8'hFE);
    wr(1'b1, 8'hA5, 8'h70);
    hi = 0; first = -1;
    for (int i = 1; i <= 600; i++) begin
      @(negedge clk);
      if (chip_rst_o) begin hi++; if (first < 0) first = i; end
    end
    chk("R10", "reset width", hi, 518);
    chk("R10", "reset start", first, 4);
    chk("R8", "rsten kept", rd_stat_o, 8'hDF);
    chk("R8", "ctl restored", rd_ctl_o, 8'h48);
    rd_stat();
    wr(1'b1, 8'hA5, 8'h40);
    chk("R9", "cleared keep rsten", rd_stat_o, 8'h5F);

    done = 1'b1;
    finish_run();
  end
endmodule